// File: doc/BRIEF.md
# GPIO Remote Key Decoder

This block samples a parallel word that an external remote-control receiver drives on general-purpose pins and turns it into key events. A programmable poll period, counted in milliseconds from the system clock, sets when the word is sampled. A sample that matches the previously stored word is discarded. A sample that differs replaces the stored word and is turned into one event.

For each event, the bits picked out by a keycode mask are packed into a dense code. The polarity configuration then decides whether the event is a press or a release. Three polarity schemes are supported: an active-high down mask, an active-low up mask, or no masks at all. With no masks, every new code gives a press followed by a release. A NEC mode splits the packed code into a 16-bit address and an 8-bit command, and a fixed hardware mask stands in when no keycode mask is programmed.

The code output holds its value between events. The press and release strobes are one clock wide.

Top module: `gpio_key_decoder`

## Requirements
- R1: After reset, code_o, nec_addr_o and nec_cmd_o are zero, and press_o and release_o are low.
- R2: The stored word is zero after reset. A poll whose sample equals the stored word raises no strobe and leaves code_o unchanged. A poll whose sample differs stores the new word and produces exactly one event, or one press/release pair under R7.
- R3: For each set bit of the effective keycode mask, taken in ascending bit order, the corresponding sample bit is placed at the next code bit, starting at code bit 0. Any selected bits beyond CODE_W are dropped, and unused high code bits are zero.
- R4: When keycode_mask_i is zero, hw_mask_i serves as the effective keycode mask. For example, hw_mask_i = 0x3f yields a 6-bit command.
- R5: With nec_mode_i low and keydown_mask_i non-zero, an event is a press when any sample bit selected by keydown_mask_i is 1. Otherwise it is a release.
- R6: With nec_mode_i low, keydown_mask_i zero and keyup_mask_i non-zero, an event is a press when every sample bit selected by keyup_mask_i is 0. Otherwise it is a release.
- R7: With nec_mode_i low and both polarity masks zero, an event gives press_o in one cycle and release_o in the next, and code_o carries the new code during both.
- R8: With nec_mode_i high, an event is a press when every sample bit selected by keyup_mask_i is 0, and keydown_mask_i is ignored. nec_addr_o is code bits 23:8 and nec_cmd_o is code bits 7:0.
- R9: A poll happens every period_ms_i × CYC_PER_MS clock cycles. A period of 0 acts as 1. CYC_PER_MS is CLK_HZ/1000, with a minimum of 2.
- R10: press_o and release_o are single-cycle pulses and never high together. code_o changes only in a cycle where a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | GPIO_W | Word from the remote receiver |
| period_ms_i | input | PER_W | Poll period in milliseconds |
| keycode_mask_i | input | GPIO_W | Bits gathered into the code |
| hw_mask_i | input | GPIO_W | Fallback keycode mask |
| keydown_mask_i | input | GPIO_W | Active-high press bits |
| keyup_mask_i | input | GPIO_W | Active-low press bits |
| nec_mode_i | input | 1 | Enables the address/command split |
| code_o | output | CODE_W | Packed key code, held between events |
| nec_addr_o | output | 16 | Address field of the code |
| nec_cmd_o | output | 8 | Command field of the code |
| press_o | output | 1 | One-cycle press strobe |
| release_o | output | 1 | One-cycle release strobe |

## Verification
The bench repeats unchanged samples, including the all-zero word right after reset. A design that compared against the packed code rather than the raw word, or that forgot the stored word, would emit spurious or missing strobes there. The gathering is exercised with sparse masks, masks wider than the code and the hardware-mask fallback, so an off-by-one packing index or ignoring the fallback shows up as a wrong code. Polarity checks cover mode priority: NEC must ignore the down mask, and the down mask must win over the up mask. The time between consecutive events is measured for several periods, including zero, which catches miscounted prescalers.

// File: rtl/gpio_key_pkg.sv
package gpio_key_pkg;
  localparam int unsigned NEC_ADDR_W = 16;
  localparam int unsigned NEC_CMD_W  = 8;

  typedef enum logic [1:0] {
    MODE_NEC  = 2'd0,
    MODE_HIGH = 2'd1,
    MODE_LOW  = 2'd2,
    MODE_PAIR = 2'd3
  } key_mode_e;
endpackage

// File: rtl/gpio_key_poll_timer.sv
module gpio_key_poll_timer #(
  parameter int unsigned CYC_PER_MS = 2,
  parameter int unsigned PER_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_ms_i,
  output logic             poll_o
);
  localparam int unsigned CNT_W = (CYC_PER_MS > 2) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_PER_MS - 1);

  logic [CNT_W-1:0] cyc_q;
  logic [PER_W-1:0] ms_q;
  logic [PER_W-1:0] eff_last;
  logic             ms_tick;
  logic             last_ms;

  assign ms_tick  = (cyc_q == CNT_LAST);
  assign eff_last = (period_ms_i == '0) ? '0 : period_ms_i - PER_W'(1);
  assign last_ms  = (ms_q >= eff_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      ms_q   <= '0;
      poll_o <= 1'b0;
    end else begin
      cyc_q  <= ms_tick ? '0 : cyc_q + CNT_W'(1);
      poll_o <= ms_tick && last_ms;
      if (ms_tick) ms_q <= last_ms ? '0 : ms_q + PER_W'(1);
    end
  end

  // R9: polls are at least CYC_PER_MS >= 2 cycles apart
  a_r9_poll_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_o |=> !poll_o);
endmodule

// File: rtl/gpio_key_gather.sv
module gpio_key_gather #(
  parameter int unsigned GPIO_W = 32,
  parameter int unsigned CODE_W = 24
) (
  input  logic [GPIO_W-1:0] word_i,
  input  logic [GPIO_W-1:0] mask_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned IDX_W = $clog2(GPIO_W + 1);

  // slot[i] = number of mask bits set below bit i
  logic [IDX_W-1:0] slot [GPIO_W+1];

  assign slot[0] = '0;
  for (genvar i = 0; i < GPIO_W; i++) begin : g_slot
    assign slot[i+1] = slot[i] + IDX_W'(mask_i[i]);
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < GPIO_W; i++) begin
      if (mask_i[i] && (32'(slot[i]) < CODE_W)) code_o[slot[i]] = word_i[i];
    end
  end
endmodule

// File: rtl/gpio_key_classifier.sv
module gpio_key_classifier
  import gpio_key_pkg::*;
#(
  parameter int unsigned GPIO_W = 32,
  parameter int unsigned CODE_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [GPIO_W-1:0] keydown_mask_i,
  input  logic [GPIO_W-1:0] keyup_mask_i,
  input  logic              nec_mode_i,
  output logic [CODE_W-1:0] code_o,
  output logic              press_o,
  output logic              release_o
);
  logic [GPIO_W-1:0] last_q;
  logic              pend_q;
  logic              changed;
  logic              dn_hit;
  logic              up_clear;
  key_mode_e         mode;

  assign changed  = poll_i && (gpio_i != last_q);
  assign dn_hit   = |(gpio_i & keydown_mask_i);
  assign up_clear = ~|(gpio_i & keyup_mask_i);

  // priority: NEC, then down mask, then up mask, then paired
  always_comb begin
    if (nec_mode_i)                 mode = MODE_NEC;
    else if (keydown_mask_i != '0)  mode = MODE_HIGH;
    else if (keyup_mask_i != '0)    mode = MODE_LOW;
    else                            mode = MODE_PAIR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q    <= '0;
      code_o    <= '0;
      press_o   <= 1'b0;
      release_o <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      press_o   <= 1'b0;
      release_o <= pend_q;
      pend_q    <= 1'b0;
      if (changed) begin
        last_q <= gpio_i;
        code_o <= code_i;
        unique case (mode)
          MODE_NEC, MODE_LOW: begin
            press_o   <= up_clear;
            release_o <= !up_clear;
          end
          MODE_HIGH: begin
            press_o   <= dn_hit;
            release_o <= !dn_hit;
          end
          default: begin
            press_o   <= 1'b1;
            release_o <= 1'b0;
            pend_q    <= 1'b1;
          end
        endcase
      end
    end
  end

  a_r2_needs_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |-> $past(poll_i));
  a_r10_press_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o);
  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(press_o && release_o));
  a_r10_code_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> (press_o || release_o));
endmodule

// File: rtl/gpio_key_decoder.sv
module gpio_key_decoder
  import gpio_key_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned GPIO_W = 32,
  parameter int unsigned CODE_W = 24,
  parameter int unsigned PER_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [GPIO_W-1:0]     gpio_i,
  input  logic [PER_W-1:0]      period_ms_i,
  input  logic [GPIO_W-1:0]     keycode_mask_i,
  input  logic [GPIO_W-1:0]     hw_mask_i,
  input  logic [GPIO_W-1:0]     keydown_mask_i,
  input  logic [GPIO_W-1:0]     keyup_mask_i,
  input  logic                  nec_mode_i,
  output logic [CODE_W-1:0]     code_o,
  output logic [NEC_ADDR_W-1:0] nec_addr_o,
  output logic [NEC_CMD_W-1:0]  nec_cmd_o,
  output logic                  press_o,
  output logic                  release_o
);
  localparam int unsigned RAW_CYC    = CLK_HZ / 1000;
  localparam int unsigned CYC_PER_MS = (RAW_CYC < 2) ? 2 : RAW_CYC;
  localparam int unsigned NEC_W      = NEC_ADDR_W + NEC_CMD_W;
  localparam int unsigned PAD_W      = (CODE_W >= NEC_W) ? 1 : NEC_W - CODE_W;

  logic              poll;
  logic [GPIO_W-1:0] eff_mask;
  logic [CODE_W-1:0] gathered;
  logic [NEC_W-1:0]  nec_word;

  assign eff_mask = (keycode_mask_i != '0) ? keycode_mask_i : hw_mask_i;

  gpio_key_poll_timer #(.CYC_PER_MS(CYC_PER_MS), .PER_W(PER_W)) u_timer (
    .clk_i, .rst_ni, .period_ms_i, .poll_o(poll)
  );

  gpio_key_gather #(.GPIO_W(GPIO_W), .CODE_W(CODE_W)) u_gather (
    .word_i(gpio_i), .mask_i(eff_mask), .code_o(gathered)
  );

  gpio_key_classifier #(.GPIO_W(GPIO_W), .CODE_W(CODE_W)) u_class (
    .clk_i, .rst_ni, .poll_i(poll), .gpio_i, .code_i(gathered),
    .keydown_mask_i, .keyup_mask_i, .nec_mode_i,
    .code_o, .press_o, .release_o
  );

  if (CODE_W >= NEC_W) begin : g_nec_full
    assign nec_word = code_o[NEC_W-1:0];
  end else begin : g_nec_pad
    assign nec_word = {{PAD_W{1'b0}}, code_o};
  end

  assign nec_addr_o = nec_word[NEC_W-1:NEC_CMD_W];
  assign nec_cmd_o  = nec_word[NEC_CMD_W-1:0];
endmodule

// File: tb/gpio_key_decoder_test.sv
module gpio_key_decoder_test;
  localparam int CLK_HZ = 4000;
  localparam int CYC    = 4;
  localparam int GW     = 32;
  localparam int CW     = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [GW-1:0] gpio = '0, kc_mask = '0, hw_mask = '0, dn_mask = '0, up_mask = '0;
  logic [7:0]    period = 8'd1;
  logic          nec = 1'b0;
  logic [CW-1:0] code_o;
  logic [15:0]   nec_addr_o;
  logic [7:0]    nec_cmd_o;
  logic          press_o, release_o;

  always #2 clk = ~clk;

  gpio_key_decoder #(.CLK_HZ(CLK_HZ), .GPIO_W(GW), .CODE_W(CW), .PER_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .period_ms_i(period),
    .keycode_mask_i(kc_mask), .hw_mask_i(hw_mask), .keydown_mask_i(dn_mask),
    .keyup_mask_i(up_mask), .nec_mode_i(nec), .code_o(code_o),
    .nec_addr_o(nec_addr_o), .nec_cmd_o(nec_cmd_o),
    .press_o(press_o), .release_o(release_o)
  );

  int            press_cnt = 0, rel_cnt = 0;
  logic [CW-1:0] press_code = '0, rel_code = '0;
  longint        cyc = 0, ev_cyc = 0;
  int            vecs = 0, fails = 0;
  bit            done = 1'b0;
  logic [GW-1:0] last_w = '0;

  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (press_o) begin press_cnt++; press_code = code_o; ev_cyc = cyc; end
    if (release_o) begin rel_cnt++; rel_code = code_o; ev_cyc = cyc; end
  end

  function automatic logic [CW-1:0] gather(logic [GW-1:0] w, logic [GW-1:0] m);
    logic [CW-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < GW; i++)
      if (m[i]) begin
        if (k < CW) r[k] = w[i];
        k++;
      end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // drive one word and check the resulting event against the model
  task automatic apply(logic [GW-1:0] w);
    int p0 = press_cnt, r0 = rel_cnt;
    int ep = 0, er = 0;
    string req;
    logic [CW-1:0] ec;
    logic [GW-1:0] em = (kc_mask != '0) ? kc_mask : hw_mask;
    gpio = w;
    tick(CYC * ((period == 0) ? 1 : int'(period)) + 3);
    ec = gather(w, em);
    if (w == last_w) req = "R2";
    else begin
      last_w = w;
      if (nec) begin req = "R8"; if ((w & up_mask) == 0) ep = 1; else er = 1; end
      else if (dn_mask != 0) begin req = "R5"; if ((w & dn_mask) != 0) ep = 1; else er = 1; end
      else if (up_mask != 0) begin req = "R6"; if ((w & up_mask) == 0) ep = 1; else er = 1; end
      else begin req = "R7"; ep = 1; er = 1; end
    end
    check(press_cnt - p0 == ep, {req, " press count"}, press_cnt - p0, ep);
    check(rel_cnt - r0 == er, {req, " release count"}, rel_cnt - r0, er);
    if (ep != 0) check(press_code == ec, {req, " R3 press code"}, press_code, ec);
    if (er != 0) check(rel_code == ec, {req, " R3 release code"}, rel_code, ec);
    if (nec && (ep + er) != 0) begin
      check(nec_addr_o == ec[23:8], "R8 address", nec_addr_o, ec[23:8]);
      check(nec_cmd_o == ec[7:0], "R8 command", nec_cmd_o, ec[7:0]);
    end
  endtask

  task automatic wait_event();
    int base = press_cnt + rel_cnt;
    int n = 0;
    while (press_cnt + rel_cnt == base && n < 2000) begin tick(1); n++; end
  endtask

  // R9: cycles between two consecutive events equals the poll period
  task automatic measure(logic [7:0] p);
    longint t1;
    int exp;
    period = p; nec = 1'b0; kc_mask = 32'hff; dn_mask = 32'h1; up_mask = '0;
    gpio = last_w ^ 32'h100; last_w = gpio; wait_event();
    gpio = last_w ^ 32'h100; last_w = gpio; wait_event(); t1 = ev_cyc;
    gpio = last_w ^ 32'h100; last_w = gpio; wait_event();
    exp = CYC * ((p == 0) ? 1 : int'(p));
    check(ev_cyc - t1 == exp, "R9 poll interval", 32'(ev_cyc - t1), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    check(code_o == 0 && nec_addr_o == 0 && nec_cmd_o == 0, "R1 code reset", code_o, 0);
    check(!press_o && !release_o, "R1 strobes reset", {press_o, release_o}, 0);
    rst_n = 1'b1;
    period = 8'd1;

    // R2: zero word matches reset state, no event
    kc_mask = 32'hff; dn_mask = 32'h1;
    apply(32'h0);
    // R3: sparse mask packing
    kc_mask = 32'h8000_0101; dn_mask = 32'h0; up_mask = 32'h2;
    apply(32'h8000_0001);
    apply(32'h8000_0001);
    // R3: selected bits beyond the code width are dropped
    kc_mask = 32'hffff_ffff;
    apply(32'hff00_0055);
    // R4: hardware mask fallback
    kc_mask = '0; hw_mask = 32'h3f;
    apply(32'h0000_01e7);
    hw_mask = '0; kc_mask = 32'h0f0;
    // R5 vs R6 priority: down mask wins
    dn_mask = 32'h4; up_mask = 32'h4;
    apply(32'h0000_0034);
    apply(32'h0000_0030);
    // R6
    dn_mask = '0; up_mask = 32'h300;
    apply(32'h0000_0100);
    apply(32'h0000_00a0);
    // R7
    up_mask = '0;
    apply(32'h0000_0050);
    // R8: NEC ignores down mask
    nec = 1'b1; kc_mask = 32'h00ff_ffff; up_mask = 32'h8000_0000; dn_mask = 32'h1;
    apply(32'h0086_6b12);
    apply(32'h8086_6b12);
    apply(32'h0012_3456);
    nec = 1'b0;

    // R9
    measure(8'd1);
    measure(8'd3);
    measure(8'd0);
    measure(8'd5);
    period = 8'd1;

    // random mix
    for (int v = 0; v < 80; v++) begin
      int m = $urandom_range(0, 3);
      logic [GW-1:0] w;
      nec = (m == 0);
      kc_mask = ($urandom_range(0, 4) == 0) ? '0 : $urandom();
      hw_mask = $urandom();
      dn_mask = (m == 1) ? ($urandom() | 32'h1) : (m == 0 ? $urandom() : '0);
      up_mask = (m == 0 || m == 2) ? ($urandom() & 32'h0000_f00f | 32'h8) : '0;
      if ($urandom_range(0, 3) == 0) w = last_w;
      else w = ($urandom_range(0, 1) == 0) ? $urandom() : ($urandom() & 32'h0000_ffff);
      apply(w);
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule